// File: doc/BRIEF.md
# Speculative Memory Address Resolution Buffer

This block sits between a set of speculatively running tasks and data memory. The tasks are issued in program order, and each holds a small circular sequence index. Every load and store that an active task issues is recorded against its address in one of a fixed pool of entries. Each entry keeps one load bit and one store slot per task. Store data stays in the buffer and is not written to memory while its task is speculative. A load is answered either from the closest buffered store at the same address that belongs to the same task or an older one, or from memory when no such store exists.

When a task issues a store to an address that a younger task has already read, the block reports a violation and names the oldest such younger task. The task sequencer then squashes that task and every task after it. Squashing removes all of their records without touching memory. When the head task commits, the block walks its buffered stores out to memory one per cycle and then clears its load bits. Entries that hold no bits become free again. When no entry is free, a request to a new address is refused. The requester must then free space, either by squashing tasks or by committing the head task.

Top module: `arb_buffer`

## Requirements
- R1: While reset is held and in the first cycle after it, `ld_valid`, `viol_valid`, `wr_valid`, `busy` and `full` are all low.
- R2: An accepted load with no buffered store to its address from its own task or an older task sets `ld_valid` in the next cycle. `ld_data` then equals the memory word at that address. The age of task t is (t - `head_task`) mod NUM_TASKS, and the head has age 0.
- R3: An accepted load returns the data of the buffered store to its address from the task of greatest age that is not above its own age. Its own task counts.
- R4: A store from a younger task is never visible to a load from an older task.
- R5: A store to an address that a younger task has loaded sets `viol_valid` in the next cycle, with `viol_task` naming the youngest-age (oldest) such loader. A load issued after the same task's own store to that address records no load bit, so it causes no later violation.
- R6: Buffered stores never reach memory before their task commits. A `commit` pulse raises `busy` in the next cycle. The head task's stores then appear on `wr_valid`/`wr_addr`/`wr_data`, one per cycle, exactly once each. After that the task's load bits are cleared and `busy` falls.
- R7: A squash naming task s clears every record of the tasks whose age is at least the age of s. None of their stores is ever written, and later loads no longer see them.
- R8: `full` is high exactly when every entry holds at least one bit. A request to an address without an entry while `full` is high changes nothing and gives no `ld_valid`. Entries emptied by commit or squash are reused.
- R9: While `busy` is high, requests are ignored: no `ld_valid` or `viol_valid` follows and nothing is recorded. Within one cycle, squash takes priority over commit, and commit takes priority over a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Memory request present |
| req_store | input | 1 | 1 = store, 0 = load |
| req_task | input | TW | Sequence index of the issuing task |
| req_addr | input | AW | Word address of the request |
| req_wdata | input | DW | Store data |
| head_task | input | TW | Sequence index of the oldest active task |
| commit | input | 1 | Commit the head task |
| sq_valid | input | 1 | Squash request |
| sq_task | input | TW | First task to squash; all younger tasks go too |
| mem_rd_addr | output | AW | Memory read address (follows req_addr) |
| mem_rd_data | input | DW | Memory read data for mem_rd_addr |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | DW | Load result |
| viol_valid | output | 1 | Dependence violation detected |
| viol_task | output | TW | Oldest task that must be squashed |
| wr_valid | output | 1 | Commit write to memory |
| wr_addr | output | AW | Commit write address |
| wr_data | output | DW | Commit write data |
| busy | output | 1 | Commit drain in progress |
| full | output | 1 | No free entry |

## Verification
The assertions check several properties on every cycle. A load result appears only after a load that was accepted outside a drain. A violation follows only a store, and it names a task younger than the store's task. Memory writes happen only during a drain, and a drain starts only on a commit. Several properties need the bench's scenarios instead. These are the data chosen by store forwarding, which loader is flagged, the exact set of drained writes against a memory model, refused requests when the buffer is full, and the effect of squashes on later loads.

// File: rtl/arb_pkg.sv
// Package: shared types of the address resolution buffer.
// Assumes nothing beyond IEEE 1800-2017.
package arb_pkg;
    // Action selected for the current cycle, in priority order.
    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_DRAIN,
        ACT_SQUASH,
        ACT_COMMIT,
        ACT_REQ
    } arb_act_e;
endpackage

// File: rtl/arb_lookup.sv
// arb_lookup: associative search over all entries.
// It finds the entry that holds an address, the lowest free entry, and the
// lowest entry that still holds a store of the task being drained.
// Assumes an entry is occupied exactly when any of its bits is set.
module arb_lookup #(
    parameter int NE = 256,
    parameter int AW = 16,
    localparam int IW = $clog2(NE)
) (
    input  logic [NE-1:0]  occ,
    input  logic [AW-1:0]  ent_addr [NE],
    input  logic [AW-1:0]  key,
    input  logic [NE-1:0]  drain_col,
    output logic           match_hit,
    output logic [IW-1:0]  match_idx,
    output logic           free_hit,
    output logic [IW-1:0]  free_idx,
    output logic           drain_hit,
    output logic [IW-1:0]  drain_idx
);
    // Address match among occupied entries; a descending scan leaves the lowest index.
    always_comb begin
        match_hit = 1'b0;
        match_idx = '0;
        for (int e = NE - 1; e >= 0; e--) begin
            if (occ[e] && ent_addr[e] == key) begin
                match_hit = 1'b1;
                match_idx = IW'(e);
            end
        end
    end

    // Lowest unoccupied entry, used for allocation.
    always_comb begin
        free_hit = 1'b0;
        free_idx = '0;
        for (int e = NE - 1; e >= 0; e--) begin
            if (!occ[e]) begin
                free_hit = 1'b1;
                free_idx = IW'(e);
            end
        end
    end

    // Lowest entry still holding a store of the draining task.
    always_comb begin
        drain_hit = 1'b0;
        drain_idx = '0;
        for (int e = NE - 1; e >= 0; e--) begin
            if (drain_col[e]) begin
                drain_hit = 1'b1;
                drain_idx = IW'(e);
            end
        end
    end
endmodule

// File: rtl/arb_forward.sv
// arb_forward: picks load data for one entry.
// It returns the store of the task of greatest age that is not above the
// requester's age, counting the requester itself. With no such store it
// falls back to memory.
// Assumes NT is a power of two, so that task indices wrap as ages do.
module arb_forward #(
    parameter int NT = 4,
    parameter int DW = 32,
    localparam int TW = $clog2(NT)
) (
    input  logic [NT-1:0]          st_row,
    input  logic [NT-1:0][DW-1:0]  data_row,
    input  logic [TW-1:0]          head,
    input  logic [TW-1:0]          task_id,
    input  logic [DW-1:0]          mem_data,
    output logic [DW-1:0]          ld_data
);
    // Ascending age scan; the last qualifying store wins.
    always_comb begin
        logic [TW-1:0] own_age;
        logic [TW-1:0] tk;
        own_age = task_id - head;
        ld_data = mem_data;
        for (int a = 0; a < NT; a++) begin
            tk = head + TW'(a);
            if (TW'(a) <= own_age && st_row[tk]) begin
                ld_data = data_row[tk];
            end
        end
    end
endmodule

// File: rtl/arb_violation.sv
// arb_violation: finds the youngest-age task that is younger than the
// storing task and holds a load bit in the entry.
// Assumes NT is a power of two.
module arb_violation #(
    parameter int NT = 4,
    localparam int TW = $clog2(NT)
) (
    input  logic [NT-1:0]  ld_row,
    input  logic [TW-1:0]  head,
    input  logic [TW-1:0]  task_id,
    output logic           hit,
    output logic [TW-1:0]  target
);
    // Descending age scan; the last qualifying loader is the oldest one.
    always_comb begin
        logic [TW-1:0] own_age;
        logic [TW-1:0] tk;
        own_age = task_id - head;
        hit     = 1'b0;
        target  = '0;
        for (int a = NT - 1; a >= 0; a--) begin
            tk = head + TW'(a);
            if (TW'(a) > own_age && ld_row[tk]) begin
                hit    = 1'b1;
                target = tk;
            end
        end
    end
endmodule

// File: rtl/arb_buffer.sv
// arb_buffer: speculative memory address resolution buffer.
// Each entry holds an address, one load bit and one store slot per task.
// The per-cycle priority is: drain in progress, squash, commit, request.
// A commit drains the head task's stores one per cycle, then clears its
// load bits. Assumes NT is a power of two and at least 2, and that
// head_task stays stable while busy is high.
module arb_buffer #(
    parameter int NE = 256,
    parameter int NT = 4,
    parameter int AW = 16,
    parameter int DW = 32,
    localparam int TW = $clog2(NT),
    localparam int IW = $clog2(NE)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic           req_store,
    input  logic [TW-1:0]  req_task,
    input  logic [AW-1:0]  req_addr,
    input  logic [DW-1:0]  req_wdata,
    input  logic [TW-1:0]  head_task,
    input  logic           commit,
    input  logic           sq_valid,
    input  logic [TW-1:0]  sq_task,
    output logic [AW-1:0]  mem_rd_addr,
    input  logic [DW-1:0]  mem_rd_data,
    output logic           ld_valid,
    output logic [DW-1:0]  ld_data,
    output logic           viol_valid,
    output logic [TW-1:0]  viol_task,
    output logic           wr_valid,
    output logic [AW-1:0]  wr_addr,
    output logic [DW-1:0]  wr_data,
    output logic           busy,
    output logic           full
);
    import arb_pkg::*;

    // Entry storage.
    logic [NT-1:0]          ld_bits  [NE];
    logic [NT-1:0]          st_bits  [NE];
    logic [AW-1:0]          ent_addr [NE];
    logic [NT-1:0][DW-1:0]  ent_data [NE];

    logic [TW-1:0]  drain_task;
    logic [NE-1:0]  occ;
    logic [NE-1:0]  drain_col;

    logic           match_hit, free_hit, drain_hit;
    logic [IW-1:0]  match_idx, free_idx, drain_idx, slot;
    logic           accept;

    logic [NT-1:0]          row_ld, row_st, sq_mask;
    logic [NT-1:0][DW-1:0]  row_data;
    logic [DW-1:0]          fwd_data;
    logic                   v_hit;
    logic [TW-1:0]          v_target;
    arb_act_e               act;

    // Per-entry occupancy and drain column.
    for (genvar e = 0; e < NE; e++) begin : g_ent
        assign occ[e]       = |(ld_bits[e] | st_bits[e]);
        assign drain_col[e] = st_bits[e][drain_task];
    end

    assign mem_rd_addr = req_addr;
    assign full        = &occ;

    arb_lookup #(.NE(NE), .AW(AW)) u_lookup (
        .occ       (occ),
        .ent_addr  (ent_addr),
        .key       (req_addr),
        .drain_col (drain_col),
        .match_hit (match_hit),
        .match_idx (match_idx),
        .free_hit  (free_hit),
        .free_idx  (free_idx),
        .drain_hit (drain_hit),
        .drain_idx (drain_idx)
    );

    // Row seen by the request: the matched entry, or an empty row for a new address.
    always_comb begin
        row_ld   = match_hit ? ld_bits[match_idx]  : '0;
        row_st   = match_hit ? st_bits[match_idx]  : '0;
        row_data = match_hit ? ent_data[match_idx] : '0;
        accept   = match_hit || free_hit;
        slot     = match_hit ? match_idx : free_idx;
    end

    arb_forward #(.NT(NT), .DW(DW)) u_forward (
        .st_row   (row_st),
        .data_row (row_data),
        .head     (head_task),
        .task_id  (req_task),
        .mem_data (mem_rd_data),
        .ld_data  (fwd_data)
    );

    arb_violation #(.NT(NT)) u_violation (
        .ld_row  (row_ld),
        .head    (head_task),
        .task_id (req_task),
        .hit     (v_hit),
        .target  (v_target)
    );

    // Tasks whose age is at least the age of the squashed task.
    always_comb begin
        for (int t = 0; t < NT; t++) begin
            sq_mask[t] = (TW'(t) - head_task) >= (sq_task - head_task);
        end
    end

    // Priority decode of this cycle's action.
    always_comb begin
        if (busy)           act = ACT_DRAIN;
        else if (sq_valid)  act = ACT_SQUASH;
        else if (commit)    act = ACT_COMMIT;
        else if (req_valid) act = ACT_REQ;
        else                act = ACT_IDLE;
    end

    // Bits, drain control and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < NE; e++) begin
                ld_bits[e] <= '0;
                st_bits[e] <= '0;
            end
            busy       <= 1'b0;
            drain_task <= '0;
            ld_valid   <= 1'b0;
            ld_data    <= '0;
            viol_valid <= 1'b0;
            viol_task  <= '0;
            wr_valid   <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
        end else begin
            ld_valid   <= 1'b0;
            viol_valid <= 1'b0;
            wr_valid   <= 1'b0;
            case (act)
                ACT_DRAIN: begin
                    if (drain_hit) begin
                        wr_valid <= 1'b1;
                        wr_addr  <= ent_addr[drain_idx];
                        wr_data  <= ent_data[drain_idx][drain_task];
                        st_bits[drain_idx][drain_task] <= 1'b0;
                    end else begin
                        for (int e = 0; e < NE; e++) begin
                            ld_bits[e][drain_task] <= 1'b0;
                        end
                        busy <= 1'b0;
                    end
                end
                ACT_SQUASH: begin
                    for (int e = 0; e < NE; e++) begin
                        ld_bits[e] <= ld_bits[e] & ~sq_mask;
                        st_bits[e] <= st_bits[e] & ~sq_mask;
                    end
                end
                ACT_COMMIT: begin
                    busy       <= 1'b1;
                    drain_task <= head_task;
                end
                ACT_REQ: begin
                    if (accept) begin
                        if (req_store) begin
                            st_bits[slot][req_task] <= 1'b1;
                            viol_valid <= v_hit;
                            viol_task  <= v_target;
                        end else begin
                            ld_valid <= 1'b1;
                            ld_data  <= fwd_data;
                            if (!row_st[req_task]) begin
                                ld_bits[slot][req_task] <= 1'b1;
                            end
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Address and store data of the accepted request.
    always_ff @(posedge clk) begin
        if (act == ACT_REQ && accept) begin
            ent_addr[slot] <= req_addr;
            if (req_store) begin
                ent_data[slot][req_task] <= req_wdata;
            end
        end
    end
endmodule

// File: rtl/arb_checker.sv
// arb_checker: temporal properties of arb_buffer seen at its ports.
// Assumes it is attached through the bind below.
module arb_checker #(
    parameter int NT = 4,
    localparam int TW = $clog2(NT)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           req_valid,
    input logic           req_store,
    input logic [TW-1:0]  req_task,
    input logic [TW-1:0]  head_task,
    input logic           commit,
    input logic           sq_valid,
    input logic           busy,
    input logic           ld_valid,
    input logic           viol_valid,
    input logic [TW-1:0]  viol_task,
    input logic           wr_valid,
    input logic           full
);
    logic [TW-1:0] head_q, task_q, viol_age, req_age;

    // Registered copies of head and requester, for the age comparison.
    always_ff @(posedge clk) begin
        head_q <= head_task;
        task_q <= req_task;
    end

    assign viol_age = viol_task - head_q;
    assign req_age  = task_q - head_q;

    // R1: outputs idle right after reset.
    p_idle_after_reset_r1: assert property (@(posedge clk)
        $past(!rst_n) |-> (!ld_valid && !viol_valid && !wr_valid && !busy && !full));

    // R2: a load result follows only an accepted load outside a drain.
    p_ld_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> $past(req_valid && !req_store && !busy && !sq_valid && !commit));

    // R5: a violation follows only a store.
    p_viol_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        viol_valid |-> $past(req_valid && req_store));

    // R5: the flagged task is younger than the storing task.
    p_viol_younger_r5: assert property (@(posedge clk) disable iff (!rst_n)
        viol_valid |-> (viol_age > req_age));

    // R6: memory writes happen only during a drain.
    p_wr_in_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> $past(busy));

    // R6: a drain starts only on a commit.
    p_drain_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(commit));

    // R9: no request result follows a drain cycle.
    p_quiet_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!ld_valid && !viol_valid));
endmodule

bind arb_buffer arb_checker #(.NT(NT)) u_arb_checker (.*);

// File: tb/test_arb_buffer.sv
`timescale 1ns/1ps
module test_arb_buffer;
    localparam int NE = 256;
    localparam int NT = 4;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int TW = 2;
    localparam int MW = 1024;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           req_valid = 1'b0, req_store = 1'b0;
    logic [TW-1:0]  req_task = '0;
    logic [AW-1:0]  req_addr = '0;
    logic [DW-1:0]  req_wdata = '0;
    logic [TW-1:0]  head_task = '0;
    logic           commit = 1'b0, sq_valid = 1'b0;
    logic [TW-1:0]  sq_task = '0;
    logic [AW-1:0]  mem_rd_addr;
    logic [DW-1:0]  mem_rd_data;
    logic           ld_valid, viol_valid, wr_valid, busy, full;
    logic [DW-1:0]  ld_data, wr_data;
    logic [TW-1:0]  viol_task;
    logic [AW-1:0]  wr_addr;

    logic [DW-1:0]  mem     [MW];
    logic [DW-1:0]  ref_mem [MW];
    bit             m_st [NT][MW];
    bit             m_ld [NT][MW];
    logic [DW-1:0]  m_sd [NT][MW];

    int n_tests = 0, n_fail = 0;
    bit last_viol;
    logic [TW-1:0] last_viol_task;
    logic [DW-1:0] last_ld;

    always #4 clk = ~clk;

    assign mem_rd_data = mem[mem_rd_addr[9:0]];

    // Bench memory takes the commit write stream.
    always @(posedge clk) if (wr_valid) mem[wr_addr[9:0]] <= wr_data;

    arb_buffer #(.NE(NE), .NT(NT), .AW(AW), .DW(DW)) i_arb_buffer (.*);

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [TW-1:0] age(input logic [TW-1:0] t);
        return t - head_task;
    endfunction

    // Expected load value from the model (R2, R3, R4).
    function automatic logic [DW-1:0] exp_load(input logic [TW-1:0] t, input int a);
        logic [DW-1:0] v = ref_mem[a];
        for (int k = 0; k <= int'(age(t)); k++) begin
            logic [TW-1:0] tk = head_task + TW'(k);
            if (m_st[tk][a]) v = m_sd[tk][a];
        end
        return v;
    endfunction

    // One request; refused marks a request the buffer must drop (R8).
    task automatic do_op(input bit st, input logic [TW-1:0] t, input int a,
                         input logic [DW-1:0] d, input bit refused);
        logic [DW-1:0] e_ld = exp_load(t, a);
        bit            e_v = 1'b0;
        logic [TW-1:0] e_vt = '0;
        for (int k = NT - 1; k > int'(age(t)); k--) begin
            logic [TW-1:0] tk = head_task + TW'(k);
            if (m_ld[tk][a]) begin e_v = 1'b1; e_vt = tk; end
        end
        @(negedge clk);
        req_valid = 1'b1; req_store = st; req_task = t; req_addr = AW'(a); req_wdata = d;
        @(posedge clk); #1;
        req_valid = 1'b0;
        last_viol = viol_valid; last_viol_task = viol_task; last_ld = ld_data;
        if (refused) begin
            check(!ld_valid && !viol_valid, "R8 refused request", {ld_valid, viol_valid}, 0);
        end else if (st) begin
            check(viol_valid == e_v, "R5 violation flag", viol_valid, e_v);
            if (e_v) check(viol_task == e_vt, "R5 violation task", viol_task, e_vt);
            m_st[t][a] = 1'b1; m_sd[t][a] = d;
        end else begin
            check(ld_valid && ld_data == e_ld, "R3 load data", ld_data, e_ld);
            if (!m_st[t][a]) m_ld[t][a] = 1'b1;
        end
    endtask

    task automatic do_squash(input logic [TW-1:0] s);
        logic [TW-1:0] sa = age(s);
        @(negedge clk);
        sq_valid = 1'b1; sq_task = s;
        @(posedge clk); #1;
        sq_valid = 1'b0;
        for (int t = 0; t < NT; t++) begin
            if (age(TW'(t)) >= sa) begin
                for (int a = 0; a < MW; a++) begin m_st[t][a] = 1'b0; m_ld[t][a] = 1'b0; end
            end
        end
    endtask

    // Commit the head task; poke drives a load during the drain (R9).
    task automatic do_commit(input bit poke);
        int n_exp = 0, n_got = 0;
        bit mism = 1'b0;
        for (int a = 0; a < MW; a++) if (m_st[head_task][a]) n_exp++;
        @(negedge clk);
        commit = 1'b1;
        @(posedge clk); #1;
        commit = 1'b0;
        check(busy == 1'b1, "R6 busy after commit", busy, 1);
        if (poke) begin
            @(negedge clk);
            req_valid = 1'b1; req_store = 1'b0; req_task = head_task; req_addr = 16'd5;
            @(posedge clk); #1;
            req_valid = 1'b0;
            check(!ld_valid, "R9 request ignored in drain", ld_valid, 0);
        end
        forever begin
            if (wr_valid) begin
                n_got++;
                if (wr_addr >= AW'(MW) || !m_st[head_task][wr_addr[9:0]] ||
                    m_sd[head_task][wr_addr[9:0]] != wr_data) mism = 1'b1;
            end
            if (!busy) break;
            @(posedge clk); #1;
        end
        check(!mism, "R6 drained write content", mism, 0);
        check(n_got == n_exp, "R6 drained write count", n_got, n_exp);
        for (int a = 0; a < MW; a++) begin
            if (m_st[head_task][a]) ref_mem[a] = m_sd[head_task][a];
            m_st[head_task][a] = 1'b0; m_ld[head_task][a] = 1'b0;
        end
        @(negedge clk);
        head_task = head_task + 1'b1;
        @(posedge clk); #1;
        begin
            bit same = 1'b1;
            for (int a = 0; a < MW; a++) if (mem[a] != ref_mem[a]) same = 1'b0;
            check(same, "R6 memory matches model", same, 1);
        end
    endtask

    task automatic report;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        report();
    end

    initial begin
        void'($urandom(32'h5eed));
        for (int a = 0; a < MW; a++) begin
            mem[a] = 32'h1000_0000 + a * 7;
            ref_mem[a] = mem[a];
        end
        repeat (3) @(posedge clk);
        #1;
        check(!ld_valid && !viol_valid && !wr_valid && !busy && !full, "R1 reset outputs",
              {ld_valid, viol_valid, wr_valid, busy, full}, 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check(!busy && !full && !wr_valid, "R1 after reset", {busy, full, wr_valid}, 0);

        // Directed: forwarding, isolation, violation, squash.
        do_op(0, 0, 5, 0, 0);
        check(last_ld == ref_mem[5], "R2 load from memory", last_ld, ref_mem[5]);
        do_op(1, 1, 5, 32'hA, 0);
        check(!last_viol, "R5 older loader not flagged", last_viol, 0);
        do_op(0, 2, 5, 0, 0);
        check(last_ld == 32'hA, "R3 forward older store", last_ld, 32'hA);
        do_op(0, 0, 5, 0, 0);
        check(last_ld == ref_mem[5], "R4 younger store hidden", last_ld, ref_mem[5]);
        do_op(1, 3, 5, 32'hB, 0);
        do_op(0, 2, 5, 0, 0);
        check(last_ld == 32'hA, "R3 nearest older store", last_ld, 32'hA);
        do_op(1, 1, 5, 32'hC, 0);
        check(last_viol && last_viol_task == 2, "R5 oldest younger loader", last_viol_task, 2);
        do_squash(2);
        do_op(0, 3, 5, 0, 0);
        check(last_ld == 32'hC, "R7 squashed store gone", last_ld, 32'hC);
        do_op(1, 2, 7, 32'hD, 0);
        do_op(0, 2, 7, 0, 0);
        check(last_ld == 32'hD, "R3 own store forwarded", last_ld, 32'hD);
        do_op(1, 1, 7, 32'hE, 0);
        check(!last_viol, "R5 load after own store not flagged", last_viol, 0);
        check(mem[5] == 32'h1000_0000 + 5 * 7, "R6 no write before commit", mem[5], 32'h1000_0000 + 35);
        do_commit(1);
        do_commit(0);
        check(mem[5] == 32'hC && mem[7] == 32'hE, "R6 committed data", {mem[5], mem[7]}, {32'hC, 32'hE});

        // Constrained random traffic against the model.
        for (int i = 0; i < 2500; i++) begin
            int r = int'($urandom % 64);
            if (r < 3) begin
                do_commit(0);
            end else if (r < 5) begin
                do_squash(TW'($urandom));
            end else begin
                do_op(1'($urandom), TW'($urandom), int'($urandom % 16), $urandom, 0);
                if (last_viol) do_squash(last_viol_task);
            end
        end

        // R8: fill every entry, then refuse a new address.
        do_squash(head_task);
        check(!full, "R8 empty after squash", full, 0);
        for (int i = 0; i < NE; i++) do_op(0, head_task + 2'd1, 100 + i, 0, 0);
        check(full, "R8 full when all entries used", full, 1);
        do_op(1, head_task, 600, 32'hBAD, 1);
        do_op(0, head_task + 2'd2, 600, 0, 1);
        do_commit(0);
        check(full, "R8 still full", full, 1);
        do_squash(head_task);
        check(!full, "R8 entries freed", full, 0);
        do_op(0, head_task, 600, 0, 0);
        check(last_ld == ref_mem[600], "R8 reuse after free", last_ld, ref_mem[600]);
        report();
    end
endmodule